// File: doc/BRIEF.md
# Voice-Coil DAC Code Register with I2C Slave Front End

This block is the serial control port of a 10-bit current-output DAC that drives a voice-coil actuator. An I2C master writes a two-byte frame into a 16-bit holding register. The frame carries a DAC code and a power-down flag. The master can also read the holding register back. SCL and SDA are sampled by a system clock that runs at least 16 times the bus rate, so bus rates up to 400 kHz are supported. SDA is driven only as an open-drain pull-down enable. No clock stretching is done.

The device answers to a 7-bit address whose top five bits are `00011`. Its two lowest bits are don't-care. Incoming bytes are collected in the holding register. The DAC-facing outputs change only when a full 16-bit frame has arrived. A completed two-byte read leaves the holding register at zero. A stop or a repeated start at any point abandons the transfer in progress.

Top module: `vcm_dac_i2c_slave`

## Requirements
- R1: Address bytes with bits 7:3 equal to `00011` select the block, whatever the values of bits 2:1: write bytes 0x18/0x1A/0x1C/0x1E and read bytes 0x19/0x1B/0x1D/0x1F. Bit 0 is R/W, with 1 meaning read. Any other address is not acknowledged, and the bus is ignored (never driven, no register change) until the next start.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Either one aborts any transfer in progress, and a start always begins a fresh address phase. SDA is taken as data only on SCL rising edges.
- R3: After an address byte that matches, the block pulls SDA low during the SCL low phase before the ninth clock. It keeps SDA low throughout the ninth clock's high phase. It changes its SDA drive only while SCL is low.
- R4: A write carries two data bytes, high byte first and MSB first, into the 16-bit holding register. Each of the two bytes is acknowledged.
- R5: The DAC outputs change only after the 16th data bit of a write. A frame that a stop or repeated start cuts short leaves them unchanged.
- R6: Holding-register bit 15 drives `pwr_down` (active high). Bits 13:4 drive `dac_code`, with bit 13 as the MSB. Bits 14 and 3:0 affect no output.
- R7: A read returns the holding register as two bytes, high byte first and MSB first. The block releases SDA during the master's acknowledge slots.
- R8: Once both read bytes have been clocked out, the holding register is cleared to 0x0000, so the next read returns zero. The DAC outputs are not changed by this.
- R9: If the master returns NACK after the first read byte, the block stops driving SDA, and the holding register is not cleared.
- R10: Under synchronous active-low reset, `dac_code` is 0, `pwr_down` is 0 and `sda_oe` is 0.
- R11: Data bytes beyond the second in a write are not acknowledged and change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | When high, pull SDA low (open-drain enable) |
| dac_code | output | 10 | DAC code from the last complete frame |
| pwr_down | output | 1 | Power-down request from the last complete frame |

## Verification
The hardest cases to reach are the truncated frames: a stop or repeated start that arrives after the high byte has been acknowledged but before the low byte completes, and a read that the master ends with NACK after only one byte. The bench drives these bit by bit with its open-drain bus model. A scoreboard flags any DAC output change that was not queued as expected, so a partial frame that wrongly commits is caught. A later full read confirms that the register was not cleared after the one-byte read.

// File: rtl/vcm_dac_pkg.sv
// Package: shared types for the voice-coil DAC serial control port.
// Assumes byte-oriented I2C transfers with 7-bit addressing.
package vcm_dac_pkg;

    // Protocol engine state encoding
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_IGNORE
    } slv_state_e;

    localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/vcm_line_conditioner.sv
// Module: one bus line conditioner.
// Synchronises an asynchronous line into clk, then accepts a new level only
// after FILT_LEN consecutive agreeing samples. Idle level is high.
module vcm_line_conditioner #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o
);
    localparam int unsigned CNT_W = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       agree_cnt;
    logic                   level_q;
    logic                   synced;

    assign synced  = sync_q[SYNC_STAGES-1];
    assign level_o = level_q;

    // Synchroniser chain, reset to the bus idle level
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
    end

    // Glitch filter: a level change must persist FILT_LEN samples
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q   <= 1'b1;
            agree_cnt <= '0;
        end else if (synced == level_q) begin
            agree_cnt <= '0;
        end else if (agree_cnt == CNT_W'(FILT_LEN - 1)) begin
            level_q   <= synced;
            agree_cnt <= '0;
        end else begin
            agree_cnt <= agree_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/vcm_bus_sampler.sv
// Module: bus sampler.
// Conditions SCL and SDA and derives clock edges plus start/stop events.
// Assumes SDA only changes while SCL is low except for start and stop.
module vcm_bus_sampler #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_f,
    output logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    localparam int unsigned N_LINES = 2;

    logic [N_LINES-1:0] raw;
    logic [N_LINES-1:0] filt;
    logic               scl_prev, sda_prev;

    assign raw = {sda_i, scl_i};

    // One conditioner per bus line
    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        vcm_line_conditioner #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_cond (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw[g]),
            .level_o(filt[g])
        );
    end

    assign scl_f = filt[0];
    assign sda_f = filt[1];

    // Previous filtered levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_f;
            sda_prev <= sda_f;
        end
    end

    // Event decode from filtered levels
    always_comb begin
        scl_rise = scl_f & ~scl_prev;
        scl_fall = ~scl_f & scl_prev;
        start_ev = scl_f & scl_prev & sda_prev & ~sda_f;
        stop_ev  = scl_f & scl_prev & ~sda_prev & sda_f;
    end
endmodule

// File: rtl/vcm_slave_fsm.sv
// Module: I2C slave protocol engine.
// Matches the address (upper ADDR_HI_W bits only), acknowledges bytes,
// delivers write bytes, shifts read bytes out and drives SDA open-drain.
// Assumes conditioned SCL/SDA with single-cycle edge and start/stop pulses.
module vcm_slave_fsm
    import vcm_dac_pkg::*;
#(
    parameter int unsigned        REG_W     = 16,
    parameter int unsigned        ADDR_HI_W = 5,
    parameter logic [ADDR_HI_W-1:0] ADDR_HI = 5'b00011
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_f,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_ev,
    input  logic             stop_ev,
    input  logic [REG_W-1:0] in_reg,
    output logic             sda_oe,
    output logic             wr_hi_en,
    output logic             wr_lo_en,
    output logic [BYTE_W-1:0] wr_byte,
    output logic             rd_clr,
    output slv_state_e       state
);
    localparam int unsigned BIT_CNT_W = $clog2(BYTE_W + 1);
    localparam int unsigned HI_LSB    = REG_W - BYTE_W;

    logic [BIT_CNT_W-1:0] bit_cnt;
    logic [BYTE_W-1:0]    shreg;
    logic                 rw_q;
    logic                 byte_idx;
    logic                 mst_ack;

    // Protocol sequencing, one step per conditioned bus event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            rw_q     <= 1'b0;
            byte_idx <= 1'b0;
            mst_ack  <= 1'b0;
            sda_oe   <= 1'b0;
            wr_hi_en <= 1'b0;
            wr_lo_en <= 1'b0;
            wr_byte  <= '0;
            rd_clr   <= 1'b0;
        end else begin
            wr_hi_en <= 1'b0;
            wr_lo_en <= 1'b0;
            rd_clr   <= 1'b0;
            if (start_ev) begin
                state    <= ST_ADDR;
                bit_cnt  <= '0;
                byte_idx <= 1'b0;
                sda_oe   <= 1'b0;
            end else if (stop_ev) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_WR_BYTE: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_f};
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                        if (scl_fall && bit_cnt == BIT_CNT_W'(BYTE_W)) begin
                            if (state == ST_ADDR) begin
                                if (shreg[BYTE_W-1 -: ADDR_HI_W] == ADDR_HI) begin
                                    rw_q   <= shreg[0];
                                    state  <= ST_ADDR_ACK;
                                    sda_oe <= 1'b1;
                                end else begin
                                    state <= ST_IGNORE;
                                end
                            end else begin
                                state    <= ST_WR_ACK;
                                sda_oe   <= 1'b1;
                                wr_byte  <= shreg;
                                wr_hi_en <= ~byte_idx;
                                wr_lo_en <= byte_idx;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (rw_q) begin
                                state  <= ST_RD_BYTE;
                                shreg  <= in_reg[REG_W-1:HI_LSB];
                                sda_oe <= ~in_reg[REG_W-1];
                            end else begin
                                state  <= ST_WR_BYTE;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall) begin
                            sda_oe  <= 1'b0;
                            bit_cnt <= '0;
                            if (!byte_idx) begin
                                byte_idx <= 1'b1;
                                state    <= ST_WR_BYTE;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    ST_RD_BYTE: begin
                        if (scl_fall) begin
                            if (bit_cnt == BIT_CNT_W'(BYTE_W - 1)) begin
                                state   <= ST_RD_ACK;
                                sda_oe  <= 1'b0;
                                bit_cnt <= '0;
                            end else begin
                                shreg   <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_oe  <= ~shreg[BYTE_W-2];
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) mst_ack <= ~sda_f;
                        if (scl_fall) begin
                            if (byte_idx) begin
                                rd_clr <= 1'b1;
                                state  <= ST_IGNORE;
                            end else if (mst_ack) begin
                                byte_idx <= 1'b1;
                                shreg    <= in_reg[BYTE_W-1:0];
                                sda_oe   <= ~in_reg[BYTE_W-1];
                                state    <= ST_RD_BYTE;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/vcm_frame_reg.sv
// Module: holding register and DAC output register.
// The high byte is stored on its own; the DAC outputs load only together
// with the low byte. A read-complete pulse clears the holding register.
module vcm_frame_reg
    import vcm_dac_pkg::*;
#(
    parameter int unsigned REG_W    = 16,
    parameter int unsigned CODE_W   = 10,
    parameter int unsigned CODE_LSB = 4,
    parameter int unsigned PD_BIT   = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hi_en,
    input  logic              wr_lo_en,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              rd_clr,
    output logic [REG_W-1:0]  in_reg,
    output logic [CODE_W-1:0] dac_code,
    output logic              pwr_down
);
    localparam int unsigned HI_LSB = REG_W - BYTE_W;

    logic [REG_W-1:0] full_frame;

    assign full_frame = {in_reg[REG_W-1:HI_LSB], wr_byte};

    // Holding register: byte loads and read-complete clear
    always_ff @(posedge clk) begin
        if (!rst_n)        in_reg <= '0;
        else if (rd_clr)   in_reg <= '0;
        else if (wr_hi_en) in_reg[REG_W-1:HI_LSB] <= wr_byte;
        else if (wr_lo_en) in_reg[BYTE_W-1:0] <= wr_byte;
    end

    // DAC register: loaded only when the frame's last byte lands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_code <= '0;
            pwr_down <= 1'b0;
        end else if (wr_lo_en) begin
            dac_code <= full_frame[CODE_LSB +: CODE_W];
            pwr_down <= full_frame[PD_BIT];
        end
    end
endmodule

// File: rtl/vcm_dac_i2c_slave.sv
// Module: top of the voice-coil DAC serial control port.
// Conditions the bus, runs the slave protocol and holds the DAC frame.
// Assumes clk is at least 16x the SCL rate; SDA is driven open-drain.
module vcm_dac_i2c_slave
    import vcm_dac_pkg::*;
#(
    parameter int unsigned          REG_W       = 16,
    parameter int unsigned          CODE_W      = 10,
    parameter int unsigned          CODE_LSB    = 4,
    parameter int unsigned          PD_BIT      = 15,
    parameter int unsigned          ADDR_HI_W   = 5,
    parameter logic [ADDR_HI_W-1:0] ADDR_HI     = 5'b00011,
    parameter int unsigned          SYNC_STAGES = 2,
    parameter int unsigned          FILT_LEN    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [CODE_W-1:0] dac_code,
    output logic              pwr_down
);
    logic              scl_f, sda_f, scl_rise, scl_fall, start_ev, stop_ev;
    logic              wr_hi_en, wr_lo_en, rd_clr;
    logic [BYTE_W-1:0] wr_byte;
    logic [REG_W-1:0]  in_reg_w;
    slv_state_e        fsm_state;

    vcm_bus_sampler #(
        .SYNC_STAGES(SYNC_STAGES),
        .FILT_LEN   (FILT_LEN)
    ) u_sampler (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .scl_f   (scl_f),
        .sda_f   (sda_f),
        .scl_rise(scl_rise),
        .scl_fall(scl_fall),
        .start_ev(start_ev),
        .stop_ev (stop_ev)
    );

    vcm_slave_fsm #(
        .REG_W    (REG_W),
        .ADDR_HI_W(ADDR_HI_W),
        .ADDR_HI  (ADDR_HI)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .sda_f   (sda_f),
        .scl_rise(scl_rise),
        .scl_fall(scl_fall),
        .start_ev(start_ev),
        .stop_ev (stop_ev),
        .in_reg  (in_reg_w),
        .sda_oe  (sda_oe),
        .wr_hi_en(wr_hi_en),
        .wr_lo_en(wr_lo_en),
        .wr_byte (wr_byte),
        .rd_clr  (rd_clr),
        .state   (fsm_state)
    );

    vcm_frame_reg #(
        .REG_W   (REG_W),
        .CODE_W  (CODE_W),
        .CODE_LSB(CODE_LSB),
        .PD_BIT  (PD_BIT)
    ) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hi_en(wr_hi_en),
        .wr_lo_en(wr_lo_en),
        .wr_byte (wr_byte),
        .rd_clr  (rd_clr),
        .in_reg  (in_reg_w),
        .dac_code(dac_code),
        .pwr_down(pwr_down)
    );
endmodule

// File: rtl/vcm_dac_i2c_chk.sv
// Module: protocol and register checker, bound to the top module.
module vcm_dac_i2c_chk
    import vcm_dac_pkg::*;
#(
    parameter int unsigned REG_W    = 16,
    parameter int unsigned CODE_W   = 10,
    parameter int unsigned CODE_LSB = 4,
    parameter int unsigned PD_BIT   = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_f,
    input logic              sda_oe,
    input logic              start_ev,
    input logic              wr_lo_en,
    input logic              rd_clr,
    input slv_state_e        state,
    input logic [REG_W-1:0]  in_reg,
    input logic [CODE_W-1:0] dac_code,
    input logic              pwr_down
);
    AST_OE_MOVES_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_f); // R3

    AST_QUIET_WHEN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE || state == ST_IDLE) |-> !sda_oe); // R1

    AST_START_OPENS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> state == ST_ADDR); // R2

    AST_DAC_FULL_FRAME_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({pwr_down, dac_code}) |-> $past(wr_lo_en)); // R5

    AST_OUTPUTS_MATCH_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_lo_en) |-> (pwr_down == in_reg[PD_BIT]
                             && dac_code == in_reg[CODE_LSB +: CODE_W])); // R6

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_clr) |-> in_reg == '0); // R8
endmodule

bind vcm_dac_i2c_slave vcm_dac_i2c_chk #(
    .REG_W   (REG_W),
    .CODE_W  (CODE_W),
    .CODE_LSB(CODE_LSB),
    .PD_BIT  (PD_BIT)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_f   (scl_f),
    .sda_oe  (sda_oe),
    .start_ev(start_ev),
    .wr_lo_en(wr_lo_en),
    .rd_clr  (rd_clr),
    .state   (fsm_state),
    .in_reg  (in_reg_w),
    .dac_code(dac_code),
    .pwr_down(pwr_down)
);

// File: tb/vcm_dac_i2c_slave_tb.sv
// Bench: open-drain bus model, scoreboard on the DAC outputs.
module vcm_dac_i2c_slave_tb;
    localparam int Q = 10;  // quarter SCL period in clk cycles

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_drv = 1'b1;
    logic       sda_drv = 1'b1;
    logic       sda_line;
    logic       sda_oe;
    logic [9:0] dac_code;
    logic       pwr_down;

    int n_chk  = 0;
    int n_fail = 0;

    logic [10:0] exp_q[$];
    logic [10:0] model = '0;
    logic [10:0] last_seen = '0;

    always #4 clk = ~clk;

    assign sda_line = sda_drv & ~sda_oe;

    vcm_dac_i2c_slave u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_drv),
        .sda_i   (sda_line),
        .sda_oe  (sda_oe),
        .dac_code(dac_code),
        .pwr_down(pwr_down)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver side of the scoreboard: queue the expected DAC outputs
    task automatic push_expect(input logic [15:0] frame);
        logic [10:0] v;
        v = {frame[15], frame[13:4]};
        if (v != model) begin
            exp_q.push_back(v);
            model = v;
        end
    endtask

    // Monitor: every DAC output change must match the queue head
    always @(negedge clk) begin
        if (rst_n && {pwr_down, dac_code} != last_seen) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5", "unexpected DAC update", int'({pwr_down, dac_code}), int'(last_seen));
            end else begin
                logic [10:0] e;
                e = exp_q.pop_front();
                chk({pwr_down, dac_code} == e, "R6", "DAC outputs", int'({pwr_down, dac_code}), int'(e));
            end
            last_seen = {pwr_down, dac_code};
        end
    end

    task automatic bus_start;
        tick(Q); sda_drv = 1'b1;
        tick(Q); scl_drv = 1'b1;
        tick(Q); sda_drv = 1'b0;
        tick(Q); scl_drv = 1'b0;
    endtask

    task automatic bus_stop;
        tick(Q); sda_drv = 1'b0;
        tick(Q); scl_drv = 1'b1;
        tick(Q); sda_drv = 1'b1;
        tick(2 * Q);
    endtask

    task automatic send_bit(input bit b);
        tick(Q); sda_drv = b;
        tick(Q); scl_drv = 1'b1;
        tick(2 * Q); scl_drv = 1'b0;
    endtask

    // Send a byte, then sample the ninth clock at mid-high and at its end
    task automatic write_byte(input logic [7:0] b, output bit acked);
        bit a1, a2;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        tick(Q); sda_drv = 1'b1;
        tick(Q); scl_drv = 1'b1;
        tick(Q); a1 = sda_line;
        tick(Q - 1); a2 = sda_line;
        tick(1); scl_drv = 1'b0;
        acked = !a1 && !a2;
    endtask

    task automatic read_byte(input bit give_ack, output logic [7:0] d);
        sda_drv = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(2 * Q); scl_drv = 1'b1;
            tick(Q); d[i] = sda_line;
            tick(Q); scl_drv = 1'b0;
        end
        send_bit(!give_ack);
        sda_drv = 1'b1;
    endtask

    task automatic do_write(input logic [7:0] addr, input logic [15:0] frame,
                            input string req);
        bit a;
        bus_start;
        write_byte(addr, a);
        chk(a, "R3", {req, " address ack"}, a, 1);
        write_byte(frame[15:8], a);
        chk(a, "R4", {req, " high byte ack"}, a, 1);
        push_expect(frame);
        write_byte(frame[7:0], a);
        chk(a, "R4", {req, " low byte ack"}, a, 1);
        bus_stop;
    endtask

    task automatic do_read(input logic [7:0] addr, input logic [15:0] exp,
                           input string req);
        bit a;
        logic [7:0] d;
        bus_start;
        write_byte(addr, a);
        chk(a, "R3", {req, " read address ack"}, a, 1);
        read_byte(1'b1, d);
        chk(d == exp[15:8], req, "read high byte", d, exp[15:8]);
        read_byte(1'b0, d);
        chk(d == exp[7:0], req, "read low byte", d, exp[7:0]);
        bus_stop;
    endtask

    // Watchdog: a hung run is a failure and still reports
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        bit a;
        logic [7:0] d;
        tick(10);
        rst_n = 1'b1;
        tick(2);
        // R10: reset state
        chk(dac_code == 0, "R10", "dac_code after reset", dac_code, 0);
        chk(pwr_down == 0, "R10", "pwr_down after reset", pwr_down, 0);
        chk(sda_oe == 0, "R10", "sda_oe after reset", sda_oe, 0);

        // R4 R6: plain write at the base address
        do_write(8'h18, 16'h3FF0, "R4");
        // R1 R6: alias address, power-down set, unused bits set
        do_write(8'h1E, 16'hC5A7, "R1");

        // R1: foreign address is not acknowledged, following byte ignored
        bus_start;
        write_byte(8'h30, a);
        chk(!a, "R1", "foreign address nack", a, 0);
        write_byte(8'h00, a);
        chk(!a, "R1", "byte after foreign address", a, 0);
        write_byte(8'h00, a);
        bus_stop;

        // R7: readback through an alias, then R8: register cleared
        do_read(8'h1B, 16'hC5A7, "R7");
        do_read(8'h19, 16'h0000, "R8");
        chk({pwr_down, dac_code} == model, "R8", "DAC kept after read clear",
            int'({pwr_down, dac_code}), int'(model));

        // R2 R5: high byte then stop, then high byte then repeated start
        bus_start;
        write_byte(8'h1A, a);
        write_byte(8'h12, a);
        chk(a, "R5", "partial high byte ack", a, 1);
        bus_stop;
        bus_start;
        write_byte(8'h1C, a);
        write_byte(8'h7F, a);
        bus_start;
        write_byte(8'h1C, a);
        chk(a, "R2", "address after repeated start", a, 1);
        write_byte(8'h80, a);
        push_expect(16'h8010);
        write_byte(8'h10, a);
        bus_stop;
        chk(dac_code == 10'h001 && pwr_down, "R5", "frame after aborts",
            int'({pwr_down, dac_code}), 11'h401);

        // R11: third data byte is not acknowledged
        bus_start;
        write_byte(8'h18, a);
        write_byte(8'h00, a);
        push_expect(16'h0050);
        write_byte(8'h50, a);
        write_byte(8'hFF, a);
        chk(!a, "R11", "third byte nack", a, 0);
        bus_stop;

        // R9: master NACKs the first read byte
        bus_start;
        write_byte(8'h1D, a);
        read_byte(1'b0, d);
        chk(d == 8'h00, "R9", "single read byte", d, 0);
        tick(Q);
        chk(sda_oe == 0, "R9", "released after nack", sda_oe, 0);
        bus_stop;
        do_read(8'h1F, 16'h0050, "R9");

        tick(20);
        chk(exp_q.size() == 0, "R5", "pending DAC updates", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule